// File: doc/BRIEF.md
# Internal Data RAM Access Decoder

This block sits between the operand stage of an 8-bit microcontroller core and its 256-byte internal data RAM and special-function-register bus. Each cycle the core presents one access: an access kind, an address or register index, the two bank-select bits from the status word, and write data. The decoder works out which storage the access reaches and at which byte. It drives either the RAM port or the SFR port, never both, and returns the read byte or bit in the same cycle.

Register operands map into one of four 8-byte banks at the bottom of RAM. Bit operands below 80H map into the 16-byte bit field that starts at 20H. Direct and indirect addressing share the 80H–FFH range but reach different targets: direct goes to the SFR bus and indirect goes to upper RAM. The stack pointer is held here. Push increments it and then writes. Pop reads and then decrements it. The RAM port is assumed to read asynchronously, so a bit write merges the selected bit into the byte that is read in the same cycle.

Top module: `iram_decoder`

## Requirements
- R1: After rst_ni is released, sp_o is 07H. While acc_valid_i is low, ram_en_o and sfr_en_o are both low.
- R2: The kind codes are direct=0, indirect=1, register=2, bit=3, push=4 and pop=5. A register access (kind 2) reaches RAM byte bank*8 + addr_i[2:0], where bank is psw_bank_i. Bits addr_i[7:3] are ignored.
- R3: A direct access (kind 0) below 80H reaches the RAM byte with the same address. A direct access at 80H or above drives the SFR port with addr_i and leaves ram_en_o low.
- R4: An indirect access (kind 1) always reaches the RAM byte addr_i, including 80H–FFH.
- R5: A bit access (kind 3) below 80H reaches RAM byte 20H + addr_i[6:3]. rbit_o returns bit addr_i[2:0] of that byte.
- R6: A bit write below 80H writes the byte back with only the selected bit replaced by bit_wdata_i.
- R7: A bit access at 80H or above drives the SFR port with addr_i unchanged and raises sfr_bit_o. The bit is carried in sfr_wdata_o[0] and returned from sfr_rdata_i[0].
- R8: A push (kind 4) writes wdata_i at RAM byte sp_o+1, and sp_o then increases by one. The first push after reset lands at 08H.
- R9: A pop (kind 5) reads RAM byte sp_o into rdata_o, and sp_o then decreases by one.
- R10: The stack pointer wraps modulo 256. A push at FFH writes byte 00H, and a pop at 00H leaves sp_o at FFH.
- R11: At most one of ram_en_o and sfr_en_o is high. Kinds 6 and 7 enable neither port, and they, like every access other than push and pop, leave sp_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_kind_i | input | 3 | Access kind code |
| acc_write_i | input | 1 | Write for direct, indirect, register and bit kinds |
| addr_i | input | 8 | Address, bit address or register index |
| psw_bank_i | input | 2 | Register bank select |
| wdata_i | input | 8 | Byte write data |
| bit_wdata_i | input | 1 | Bit write value |
| rdata_o | output | 8 | Read byte |
| rbit_o | output | 1 | Read bit |
| sp_o | output | 8 | Current stack pointer |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, asynchronous |
| sfr_en_o | output | 1 | SFR access enable |
| sfr_we_o | output | 1 | SFR write enable |
| sfr_bit_o | output | 1 | SFR access is a bit access |
| sfr_addr_o | output | 8 | SFR address |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_rdata_i | input | 8 | SFR read data |

## Verification
Two things happen in the same cycle for a stack access: the RAM access, which uses the stack pointer value before the update, and the stack pointer update, which takes effect at the clock edge. Back-to-back pushes and pops, including the crossing of FFH and 00H, are therefore judged on both the address seen before the edge and sp_o after it. A bit write is likewise a read and a write of the same byte in one cycle. The bench preloads a known byte, sets and clears single bits, then reads the whole byte back directly and compares it with the byte it expects.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [2:0] {
    ACC_DIR  = 3'd0,
    ACC_IND  = 3'd1,
    ACC_REG  = 3'd2,
    ACC_BIT  = 3'd3,
    ACC_PUSH = 3'd4,
    ACC_POP  = 3'd5
  } acc_kind_e;
endpackage

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr #(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_inc_o
);
  logic [AW-1:0] sp_q;

  assign sp_inc_o = sp_q + AW'(1);
  assign sp_o     = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_RST;
    else if (push_i) sp_q <= sp_inc_o;
    else if (pop_i)  sp_q <= sp_q - AW'(1);
  end
endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
  parameter int DW = 8,
  localparam int PW = $clog2(DW)
) (
  input  logic [DW-1:0] byte_i,
  input  logic [PW-1:0] pos_i,
  input  logic          bit_i,
  output logic [DW-1:0] byte_o,
  output logic          bit_o
);
  for (genvar g = 0; g < DW; g++) begin : g_lane
    assign byte_o[g] = (pos_i == PW'(g)) ? bit_i : byte_i[g];
  end
  assign bit_o = byte_i[pos_i];
endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 2,
  parameter logic [AW-1:0] BIT_BASE = 8'h20,
  localparam int RW = 3,
  localparam int PW = 3,
  localparam int FW = AW - 1 - PW
) (
  input  logic          valid_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] sp_inc_i,
  output logic          to_ram_o,
  output logic          to_sfr_o,
  output logic          is_bit_o,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [PW-1:0] bit_pos_o
);
  logic upper;
  assign upper     = addr_i[AW-1];
  assign bit_pos_o = addr_i[PW-1:0];

  always_comb begin
    to_ram_o   = 1'b0;
    to_sfr_o   = 1'b0;
    is_bit_o   = 1'b0;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    ram_addr_o = addr_i;
    if (valid_i) begin
      case (acc_kind_e'(kind_i))
        ACC_DIR: begin
          to_ram_o = !upper;
          to_sfr_o = upper;
        end
        ACC_IND: to_ram_o = 1'b1;
        ACC_REG: begin
          to_ram_o   = 1'b1;
          ram_addr_o = {{(AW-BW-RW){1'b0}}, bank_i, addr_i[RW-1:0]};
        end
        ACC_BIT: begin
          is_bit_o   = 1'b1;
          to_ram_o   = !upper;
          to_sfr_o   = upper;
          if (!upper) ram_addr_o = BIT_BASE + {{(AW-FW){1'b0}}, addr_i[AW-2:PW]};
        end
        ACC_PUSH: begin
          to_ram_o   = 1'b1;
          push_o     = 1'b1;
          ram_addr_o = sp_inc_i;
        end
        ACC_POP: begin
          to_ram_o   = 1'b1;
          pop_o      = 1'b1;
          ram_addr_o = sp_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iram_decoder.sv
module iram_decoder
  import iram_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int BW = 2,
  parameter logic [AW-1:0] SP_RST   = 8'h07,
  parameter logic [AW-1:0] BIT_BASE = 8'h20,
  localparam int PW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [2:0]    acc_kind_i,
  input  logic          acc_write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] psw_bank_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bit_wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rbit_o,
  output logic [AW-1:0] sp_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          sfr_en_o,
  output logic          sfr_we_o,
  output logic          sfr_bit_o,
  output logic [AW-1:0] sfr_addr_o,
  output logic [DW-1:0] sfr_wdata_o,
  input  logic [DW-1:0] sfr_rdata_i
);
  logic          to_ram, to_sfr, is_bit, push, pop;
  logic [AW-1:0] sp_inc;
  logic [PW-1:0] bit_pos;
  logic [DW-1:0] merged;
  logic          ram_bit;

  iram_stack_ptr #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .sp_o, .sp_inc_o(sp_inc)
  );

  iram_addr_map #(.AW(AW), .BW(BW), .BIT_BASE(BIT_BASE)) u_map (
    .valid_i(acc_valid_i), .kind_i(acc_kind_i), .addr_i, .bank_i(psw_bank_i),
    .sp_i(sp_o), .sp_inc_i(sp_inc), .to_ram_o(to_ram), .to_sfr_o(to_sfr),
    .is_bit_o(is_bit), .push_o(push), .pop_o(pop), .ram_addr_o,
    .bit_pos_o(bit_pos)
  );

  iram_bit_merge #(.DW(DW)) u_bits (
    .byte_i(ram_rdata_i), .pos_i(bit_pos), .bit_i(bit_wdata_i),
    .byte_o(merged), .bit_o(ram_bit)
  );

  // pop never writes; push always writes
  assign ram_en_o    = to_ram;
  assign ram_we_o    = to_ram && (push || (acc_write_i && !pop));
  assign ram_wdata_o = is_bit ? merged : wdata_i;

  assign sfr_en_o    = to_sfr;
  assign sfr_we_o    = to_sfr && acc_write_i;
  assign sfr_bit_o   = to_sfr && is_bit;
  assign sfr_addr_o  = addr_i;
  assign sfr_wdata_o = is_bit ? {{(DW-1){1'b0}}, bit_wdata_i} : wdata_i;

  assign rdata_o = to_sfr ? sfr_rdata_i : ram_rdata_i;
  assign rbit_o  = to_sfr ? sfr_rdata_i[0] : ram_bit;
endmodule

// File: rtl/iram_decoder_chk.sv
module iram_decoder_chk
  import iram_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_valid_i,
  input logic [2:0] acc_kind_i,
  input logic       acc_write_i,
  input logic [7:0] addr_i,
  input logic [7:0] sp_o,
  input logic       ram_en_o,
  input logic       ram_we_o,
  input logic [7:0] ram_addr_o,
  input logic [7:0] ram_wdata_o,
  input logic [7:0] ram_rdata_i,
  input logic       sfr_en_o
);
  logic is_push, is_pop;
  assign is_push = acc_valid_i && acc_kind_i == ACC_PUSH;
  assign is_pop  = acc_valid_i && acc_kind_i == ACC_POP;

  a_r11_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_en_o, sfr_en_o}));

  a_r8_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_push |=> sp_o == $past(sp_o) + 8'd1);

  a_r8_push_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_push |-> ram_we_o && ram_addr_o == sp_o + 8'd1);

  a_r9_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pop |=> sp_o == $past(sp_o) - 8'd1);

  a_r11_sp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_push || is_pop) |=> $stable(sp_o));

  a_r3_direct_sfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_kind_i == ACC_DIR && addr_i[7]) |-> sfr_en_o && !ram_en_o);

  a_r4_indirect_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_kind_i == ACC_IND) |-> ram_en_o && ram_addr_o == addr_i);

  a_r6_bit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_kind_i == ACC_BIT && !addr_i[7] && acc_write_i) |->
      ((ram_wdata_o ^ ram_rdata_i) & ~(8'h01 << addr_i[2:0])) == 8'h00);
endmodule

bind iram_decoder iram_decoder_chk u_chk (
  .clk_i, .rst_ni, .acc_valid_i, .acc_kind_i, .acc_write_i, .addr_i, .sp_o,
  .ram_en_o, .ram_we_o, .ram_addr_o, .ram_wdata_o, .ram_rdata_i, .sfr_en_o
);

// File: tb/tb_iram_decoder.sv
module tb_iram_decoder;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       acc_valid_i = 1'b0, acc_write_i = 1'b0, bit_wdata_i = 1'b0;
  logic [2:0] acc_kind_i = '0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [1:0] psw_bank_i = '0;
  logic [7:0] rdata_o, sp_o, ram_addr_o, ram_wdata_o, ram_rdata_i;
  logic [7:0] sfr_addr_o, sfr_wdata_o, sfr_rdata_i;
  logic       rbit_o, ram_en_o, ram_we_o, sfr_en_o, sfr_we_o, sfr_bit_o;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  logic [7:0] mem [256];
  assign ram_rdata_i = mem[ram_addr_o];
  assign sfr_rdata_i = ~sfr_addr_o;
  always @(posedge clk) if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;

  iram_decoder dut (.clk_i(clk), .*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] k, logic w, logic [7:0] a, logic [1:0] b,
                       logic [7:0] d, logic bd);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_kind_i = k; acc_write_i = w; addr_i = a;
    psw_bank_i = b; wdata_i = d; bit_wdata_i = bd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
    #1;
  endtask

  // kind, bank, addr, exp_ram, exp_sfr, exp_addr
  localparam logic [22:0] VECS [10] = '{
    {3'd2, 2'd0, 8'h05, 1'b1, 1'b0, 8'h05},
    {3'd2, 2'd3, 8'h07, 1'b1, 1'b0, 8'h1F},
    {3'd2, 2'd2, 8'hF8, 1'b1, 1'b0, 8'h10},
    {3'd0, 2'd1, 8'h7F, 1'b1, 1'b0, 8'h7F},
    {3'd0, 2'd1, 8'h80, 1'b0, 1'b1, 8'h80},
    {3'd1, 2'd0, 8'h80, 1'b1, 1'b0, 8'h80},
    {3'd1, 2'd2, 8'hFF, 1'b1, 1'b0, 8'hFF},
    {3'd3, 2'd0, 8'h7F, 1'b1, 1'b0, 8'h2F},
    {3'd3, 2'd0, 8'h00, 1'b1, 1'b0, 8'h20},
    {3'd3, 2'd0, 8'h85, 1'b0, 1'b1, 8'h85}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    #10 rst_ni = 1'b1;
    idle();
    chk("R1 sp reset", sp_o, 8'h07);
    chk("R1 no enable", {ram_en_o, sfr_en_o}, 2'b00);

    for (int i = 0; i < 10; i++) begin
      drive(VECS[i][22:20], 1'b0, VECS[i][17:10], VECS[i][19:18], 8'h00, 1'b0);
      chk("R2 R3 R4 R5 R7 target", {ram_en_o, sfr_en_o}, VECS[i][9:8]);
      if (VECS[i][9]) chk("R2 R3 R4 R5 ram addr", ram_addr_o, VECS[i][7:0]);
      else            chk("R3 R7 sfr addr", sfr_addr_o, VECS[i][7:0]);
    end

    // stack
    drive(3'd4, 1'b0, 8'h00, 2'd0, 8'hAA, 1'b0);
    chk("R8 first push addr", ram_addr_o, 8'h08);
    drive(3'd4, 1'b0, 8'h00, 2'd0, 8'hBB, 1'b0);
    chk("R8 sp after push", sp_o, 8'h08);
    chk("R8 second push addr", ram_addr_o, 8'h09);
    drive(3'd5, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0);
    chk("R9 pop data", rdata_o, 8'hBB);
    chk("R9 pop no write", ram_we_o, 1'b0);
    drive(3'd5, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0);
    chk("R9 sp after pop", sp_o, 8'h08);
    chk("R9 second pop data", rdata_o, 8'hAA);
    idle();
    chk("R9 sp back", sp_o, 8'h07);

    // bit read-modify-write
    drive(3'd0, 1'b1, 8'h21, 2'd0, 8'hA5, 1'b0);
    drive(3'd3, 1'b1, 8'h0B, 2'd0, 8'h00, 1'b1);
    chk("R6 set bit data", ram_wdata_o, 8'hAD);
    drive(3'd3, 1'b1, 8'h0F, 2'd0, 8'h00, 1'b0);
    drive(3'd0, 1'b0, 8'h21, 2'd0, 8'h00, 1'b0);
    chk("R6 byte after bit writes", rdata_o, 8'h2D);
    drive(3'd3, 1'b0, 8'h0A, 2'd0, 8'h00, 1'b0);
    chk("R5 bit read one", rbit_o, 1'b1);
    drive(3'd3, 1'b0, 8'h0C, 2'd0, 8'h00, 1'b0);
    chk("R5 bit read zero", rbit_o, 1'b0);

    // SFR bit and byte
    drive(3'd3, 1'b1, 8'h88, 2'd0, 8'hFF, 1'b1);
    chk("R7 sfr bit flags", {sfr_en_o, sfr_we_o, sfr_bit_o, ram_en_o}, 4'b1110);
    chk("R7 sfr bit data", sfr_wdata_o, 8'h01);
    drive(3'd3, 1'b0, 8'h89, 2'd0, 8'h00, 1'b0);
    chk("R7 sfr bit read", rbit_o, 1'b0);
    drive(3'd1, 1'b1, 8'h90, 2'd0, 8'h77, 1'b0);
    drive(3'd0, 1'b1, 8'h90, 2'd0, 8'h33, 1'b0);
    chk("R3 direct high to sfr", {sfr_we_o, ram_en_o, ram_we_o}, 3'b100);
    chk("R3 sfr write data", sfr_wdata_o, 8'h33);
    drive(3'd1, 1'b0, 8'h90, 2'd0, 8'h00, 1'b0);
    chk("R4 upper ram kept", rdata_o, 8'h77);
    drive(3'd0, 1'b0, 8'hA0, 2'd0, 8'h00, 1'b0);
    chk("R3 sfr read data", rdata_o, 8'h5F);

    // unused kind
    drive(3'd6, 1'b1, 8'h10, 2'd0, 8'h00, 1'b0);
    chk("R11 no enable", {ram_en_o, sfr_en_o}, 2'b00);
    drive(3'd7, 1'b1, 8'h10, 2'd0, 8'h00, 1'b0);
    chk("R11 sp unchanged", sp_o, 8'h07);

    // wrap
    for (int i = 0; i < 248; i++) drive(3'd4, 1'b0, 8'h00, 2'd0, 8'(i), 1'b0);
    idle();
    chk("R10 sp at top", sp_o, 8'hFF);
    drive(3'd4, 1'b0, 8'h00, 2'd0, 8'hC3, 1'b0);
    chk("R10 push wraps addr", ram_addr_o, 8'h00);
    idle();
    chk("R10 sp wrapped", sp_o, 8'h00);
    drive(3'd5, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0);
    chk("R10 pop at zero data", rdata_o, 8'hC3);
    idle();
    chk("R10 sp under wrap", sp_o, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule